// File: doc/BRIEF.md
# Sticky Error Flag Register with SMI Request

This block is a 64-bit model-specific error register for a disk-interface controller. The low word holds enables and a block-I/O control bit. The upper word holds four sticky error flags. Internal event pulses set these flags, but only while the matching enable is on. Firmware reads the whole register back and clears flags by writing ones to them.

From the stored flags and enables the block derives a level error output. It also produces two one-cycle pulses, which come out in the same cycle a qualifying flag turns on:

- a system-management interrupt (SMI) request;
- a local-bus ready strobe.

The bus protocol that carries register accesses, the DMA engine and the interrupt handler all live outside this block.

Register layout:

| Bits | Meaning |
|------|---------|
| 1 | enable for the I/O-write-during-DMA flag |
| 2 | enable for the SMI-overrun flag |
| 3 | enable for the response-exception flag |
| 4 | enable for the PIO-during-DMA flag |
| 8 | block-I/O control |
| 33 | I/O-write-during-DMA flag |
| 34 | SMI-overrun flag |
| 35 | response-exception flag |
| 36 | PIO-during-DMA flag |

Every other bit is reserved.

Top module: `errreg_top`

## Requirements
- R1: After reset, `rd_data` equals 64'h0000_0000_0000_0100, and `err_o`, `smi_req` and `lb_rdy` are 0.
- R2: A write (`wr_en`=1) loads bits 1, 2, 3, 4 and 8 from `wr_data`. All reserved bits (63:37, 32:9, 7:5, 0) always read 0, and writes to them are ignored.
- R3: On a write, a 1 in any flag bit 33..36 clears that flag in the next cycle. A 0 leaves the flag unchanged.
- R4: An event whose enable bit is 0 sets no flag and raises neither `err_o` nor `smi_req`.
- R5: `ev_pio_access`=1 together with `dma_active`=1 and enable bit 4 sets flag bit 36 at the next clock edge. Without `dma_active`, the event is ignored.
- R6: `ev_resp_excp`=1 with enable bit 3 sets flag bit 35 at the next clock edge.
- R7: `ev_smi`=1 together with `smi_pending`=1 and enable bit 2 sets flag bit 34. In the cycle the flag first reads 1, `lb_rdy` and `smi_req` pulse for that cycle.
- R8: `ev_io_write`=1 together with `dma_active`=1 sets flag bit 33, but only when enable bit 1 and control bit 8 are both 1.
- R9: `err_o` is 1 exactly when some flag bit 33+i and its enable bit 1+i (i=0..3) are both 1.
- R10: If a flag's set event and a write-one-to-clear of that flag fall in the same cycle, the flag ends up set.
- R11: `smi_req` is a one-cycle pulse in the cycle that flag 33 or flag 34 turns from 0 to 1. It also pulses when flag 36 turns on, provided `pio_smi_en` was 1 in the event cycle. Flag 35 never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write data |
| rd_data | output | 64 | Current register contents |
| dma_active | input | 1 | A DMA command is in progress |
| ev_pio_access | input | 1 | Pulse: programmed-I/O access seen |
| ev_resp_excp | input | 1 | Pulse: response packet carried an exception |
| ev_io_write | input | 1 | Pulse: I/O write seen |
| ev_smi | input | 1 | Pulse: new SMI event |
| smi_pending | input | 1 | An earlier SMI flag is still uncleared |
| pio_smi_en | input | 1 | Companion enable: PIO error also requests an SMI |
| err_o | output | 1 | Global error level |
| smi_req | output | 1 | One-cycle SMI request |
| lb_rdy | output | 1 | One-cycle local-bus ready strobe on SMI overrun |

## Verification
The assertions assume the following about the inputs:

- Every input is stable and known whenever reset is deasserted.
- The companion signals `dma_active`, `smi_pending` and `pio_smi_en` are level qualifiers, sampled in the same cycle as the event pulse.

The bench holds inputs across a whole cycle, changing them only at falling edges. It sweeps every combination of the four enables, the block-I/O bit and `dma_active` with all events fired together, and always presents `smi_pending` and `pio_smi_en` as plain levels. Single-event cases cover the remaining qualifiers and the case where a set and a clear collide on the same flag.

// File: rtl/errreg_pkg.sv
package errreg_pkg;
  localparam int REG_W    = 64;
  localparam int NFLAG    = 4;
  localparam int FLAG_LSB = 33;
  localparam int EN_LSB   = 1;
  localparam int BLK_BIT  = 8;

  localparam int IO_IDX   = 0;
  localparam int SMI_IDX  = 1;
  localparam int RESP_IDX = 2;
  localparam int PIO_IDX  = 3;

  typedef logic [NFLAG-1:0] flagvec_t;

  // flags that always request an SMI when they rise
  localparam flagvec_t SMI_FIXED = flagvec_t'((1 << IO_IDX) | (1 << SMI_IDX));
endpackage

// File: rtl/errreg_rst_sync.sv
module errreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/errreg_ctrl.sv
module errreg_ctrl
  import errreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  flagvec_t wr_en_bits,
  input  logic     wr_blk,
  output flagvec_t en_q,
  output logic     blk_q
);
  flagvec_t en_d;
  logic     blk_d;
  logic     load;

  assign load = wr_en;

  always_comb begin
    en_d  = en_q;
    blk_d = blk_q;
    if (load) begin
      en_d  = wr_en_bits;
      blk_d = wr_blk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      blk_q <= 1'b1;
    end else begin
      en_q  <= en_d;
      blk_q <= blk_d;
    end
  end
endmodule

// File: rtl/errreg_qual.sv
module errreg_qual
  import errreg_pkg::*;
(
  input  flagvec_t en_q,
  input  logic     blk_q,
  input  logic     dma_active,
  input  logic     ev_pio_access,
  input  logic     ev_resp_excp,
  input  logic     ev_io_write,
  input  logic     ev_smi,
  input  logic     smi_pending,
  output flagvec_t set_vec
);
  flagvec_t cond;

  always_comb begin
    cond           = '0;
    cond[IO_IDX]   = ev_io_write & dma_active & blk_q;
    cond[SMI_IDX]  = ev_smi & smi_pending;
    cond[RESP_IDX] = ev_resp_excp;
    cond[PIO_IDX]  = ev_pio_access & dma_active;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_gate
    assign set_vec[i] = cond[i] & en_q[i];
  end
endmodule

// File: rtl/errreg_flags.sv
module errreg_flags
  import errreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  flagvec_t set_vec,
  input  flagvec_t clr_vec,
  input  flagvec_t smi_sel,
  output flagvec_t flag_q,
  output logic     smi_q,
  output logic     rdy_q
);
  flagvec_t flag_d;
  flagvec_t rise;
  logic     smi_d;
  logic     rdy_d;

  always_comb begin
    // set has priority over a same-cycle clear
    flag_d = (flag_q & ~clr_vec) | set_vec;
    rise   = set_vec & ~flag_q;
    smi_d  = |(rise & smi_sel);
    rdy_d  = rise[SMI_IDX];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      smi_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      smi_q  <= smi_d;
      rdy_q  <= rdy_d;
    end
  end
endmodule

// File: rtl/errreg_top.sv
module errreg_top
  import errreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             dma_active,
  input  logic             ev_pio_access,
  input  logic             ev_resp_excp,
  input  logic             ev_io_write,
  input  logic             ev_smi,
  input  logic             smi_pending,
  input  logic             pio_smi_en,
  output logic             err_o,
  output logic             smi_req,
  output logic             lb_rdy
);
  logic     rst_n_i;
  flagvec_t en_q;
  logic     blk_q;
  flagvec_t set_vec;
  flagvec_t clr_vec;
  flagvec_t smi_sel;
  flagvec_t flag_q;
  logic     unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:FLAG_LSB+NFLAG],
                            wr_data[FLAG_LSB-1:BLK_BIT+1],
                            wr_data[BLK_BIT-1:EN_LSB+NFLAG],
                            wr_data[EN_LSB-1:0]};

  errreg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  errreg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .wr_en      (wr_en),
    .wr_en_bits (wr_data[EN_LSB +: NFLAG]),
    .wr_blk     (wr_data[BLK_BIT]),
    .en_q       (en_q),
    .blk_q      (blk_q)
  );

  errreg_qual u_qual (
    .en_q          (en_q),
    .blk_q         (blk_q),
    .dma_active    (dma_active),
    .ev_pio_access (ev_pio_access),
    .ev_resp_excp  (ev_resp_excp),
    .ev_io_write   (ev_io_write),
    .ev_smi        (ev_smi),
    .smi_pending   (smi_pending),
    .set_vec       (set_vec)
  );

  always_comb begin
    clr_vec = wr_en ? wr_data[FLAG_LSB +: NFLAG] : '0;
    smi_sel = SMI_FIXED;
    smi_sel[PIO_IDX] = pio_smi_en;
  end

  errreg_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .smi_sel (smi_sel),
    .flag_q  (flag_q),
    .smi_q   (smi_req),
    .rdy_q   (lb_rdy)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BLK_BIT] = blk_q;
    for (int i = 0; i < NFLAG; i++) begin
      rd_data[EN_LSB + i]   = en_q[i];
      rd_data[FLAG_LSB + i] = flag_q[i];
    end
  end

  assign err_o = |(flag_q & en_q);
endmodule

// File: rtl/errreg_chk.sv
module errreg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [63:0] wr_data,
  input logic [63:0] rd_data,
  input logic        dma_active,
  input logic        ev_pio_access,
  input logic        ev_resp_excp,
  input logic        ev_io_write,
  input logic        ev_smi,
  input logic        smi_pending,
  input logic        err_o,
  input logic        smi_req,
  input logic        lb_rdy
);
  a_r5_pio_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pio_access && dma_active && rd_data[4]) |=> rd_data[36]);

  a_r6_resp_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_resp_excp && rd_data[3]) |=> rd_data[35]);

  a_r8_iowr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_io_write && dma_active && rd_data[1] && rd_data[8]) |=> rd_data[33]);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_smi && smi_pending && rd_data[2] && wr_en && wr_data[34]) |=> rd_data[34]);

  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[35] && !(ev_resp_excp && rd_data[3])) |=> !rd_data[35]);

  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[3] && !rd_data[35] && !wr_en) |=> !rd_data[35]);

  a_r7_rdy_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[34]) |-> (lb_rdy && smi_req));

  a_r11_smi_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> (rd_data[33] || rd_data[34] || rd_data[36]));

  a_r9_err_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (rd_data[36:33] != 4'b0000));

  always @(negedge clk) begin
    if (rst_n) begin
      a_r2_rsvd_zero: assert (rd_data[63:37] == '0 && rd_data[32:9] == '0
                              && rd_data[7:5] == '0 && rd_data[0] == 1'b0);
    end
  end
endmodule

bind errreg_top errreg_chk u_errreg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .dma_active    (dma_active),
  .ev_pio_access (ev_pio_access),
  .ev_resp_excp  (ev_resp_excp),
  .ev_io_write   (ev_io_write),
  .ev_smi        (ev_smi),
  .smi_pending   (smi_pending),
  .err_o         (err_o),
  .smi_req       (smi_req),
  .lb_rdy        (lb_rdy)
);

// File: tb/errreg_top_bench.sv
module errreg_top_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic        dma_active, ev_pio_access, ev_resp_excp, ev_io_write, ev_smi;
  logic        smi_pending, pio_smi_en;
  logic        err_o, smi_req, lb_rdy;

  int n_chk  = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  localparam logic [63:0] FLAGS_ALL = 64'h0000_001E_0000_0000;

  errreg_top u_errreg_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dma_active(dma_active), .ev_pio_access(ev_pio_access), .ev_resp_excp(ev_resp_excp),
    .ev_io_write(ev_io_write), .ev_smi(ev_smi), .smi_pending(smi_pending),
    .pio_smi_en(pio_smi_en), .err_o(err_o), .smi_req(smi_req), .lb_rdy(lb_rdy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // events held for one cycle, checked in the cycle after the capturing edge
  task automatic fire(logic pio, logic resp, logic iow, logic smi,
                      logic dma, logic pend, logic psmi);
    @(negedge clk);
    ev_pio_access = pio; ev_resp_excp = resp; ev_io_write = iow; ev_smi = smi;
    dma_active = dma; smi_pending = pend; pio_smi_en = psmi;
    @(negedge clk);
    ev_pio_access = 0; ev_resp_excp = 0; ev_io_write = 0; ev_smi = 0;
    dma_active = 0; smi_pending = 0; pio_smi_en = 0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = '0;
    ev_pio_access = 0; ev_resp_excp = 0; ev_io_write = 0; ev_smi = 0;
    dma_active = 0; smi_pending = 0; pio_smi_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk64("R1 reset value", rd_data, 64'h100);
    chk1("R1 err_o", err_o, 1'b0);
    chk1("R1 smi_req", smi_req, 1'b0);
    chk1("R1 lb_rdy", lb_rdy, 1'b0);

    wr('1);
    chk64("R2 all-ones write", rd_data, 64'h11E);
    wr('0);
    chk64("R2 all-zeros write", rd_data, 64'h0);

    // full sweep of enables, block-I/O bit and dma_active
    for (int c = 0; c < 32; c++) begin
      for (int d = 0; d < 2; d++) begin
        logic [3:0]  en;
        logic        blk;
        logic [63:0] ctrl;
        logic [3:0]  fl;
        en   = c[3:0];
        blk  = c[4];
        ctrl = (64'(blk) << 8) | (64'(en) << 1);
        wr(ctrl | FLAGS_ALL);
        chk64("R2 control load", rd_data, ctrl);
        fire(1, 1, 1, 1, d[0], 1, 1);
        fl[0] = d[0] & en[0] & blk;
        fl[1] = en[1];
        fl[2] = en[2];
        fl[3] = d[0] & en[3];
        chk64("R4 R5 R6 R7 R8 flags", rd_data, ctrl | (64'(fl) << 33));
        chk1("R9 err_o", err_o, |(fl & en));
        chk1("R11 smi_req pulse", smi_req, fl[0] | fl[1] | fl[3]);
        chk1("R7 lb_rdy pulse", lb_rdy, fl[1]);
        @(negedge clk);
        chk1("R11 smi_req one cycle", smi_req, 1'b0);
        wr(ctrl);
        chk64("R3 zero write keeps flags", rd_data, ctrl | (64'(fl) << 33));
        wr(ctrl | FLAGS_ALL);
        chk64("R3 one write clears", rd_data, ctrl);
        chk1("R9 err_o after clear", err_o, 1'b0);
      end
    end

    // PIO error without companion SMI enable: flag but no SMI
    wr(64'h110);
    fire(1, 0, 0, 0, 1, 0, 0);
    chk64("R5 pio flag", rd_data, 64'h110 | (64'h1 << 36));
    chk1("R11 no smi without companion enable", smi_req, 1'b0);
    chk1("R9 err_o from pio", err_o, 1'b1);
    // repeat event on already-set flag: no new SMI
    fire(1, 0, 0, 0, 1, 0, 1);
    chk1("R11 no smi when flag already set", smi_req, 1'b0);

    // resp exception never requests SMI
    wr(64'h108 | FLAGS_ALL);
    fire(0, 1, 0, 0, 0, 0, 1);
    chk64("R6 resp flag", rd_data, 64'h108 | (64'h1 << 35));
    chk1("R11 resp no smi", smi_req, 1'b0);

    // SMI event without pending earlier SMI is ignored
    wr(64'h104 | FLAGS_ALL);
    fire(0, 0, 0, 1, 0, 0, 0);
    chk64("R7 needs smi_pending", rd_data, 64'h104);

    // set and clear collide on flag 35: set wins
    wr(64'h108 | FLAGS_ALL);
    fire(0, 1, 0, 0, 0, 0, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 64'h108 | (64'h1 << 35); ev_resp_excp = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev_resp_excp = 1'b0;
    chk64("R10 set beats clear", rd_data, 64'h108 | (64'h1 << 35));
    wr(64'h108 | FLAGS_ALL);
    chk64("R10 plain clear afterwards", rd_data, 64'h108);

    // reserved bits ignore writes
    wr(64'hFFFF_FFE0_FFFF_FEE1);
    chk64("R2 reserved ignored", rd_data, 64'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule